// File: doc/BRIEF.md
# Address Break Interrupt Unit

This block watches the CPU bus of a small microcontroller and raises an interrupt when a chosen bus cycle occurs. Every cycle with the bus strobe valid is checked against a programmed break address. A cycle-type selector limits the check to opcode fetches, data reads, data writes or any access. An optional data check compares the bus data with a 16-bit break-data value. The data lane used depends on the access width and on the address parity.

A hit sets a sticky match flag. When the interrupt enable is also set, the registered interrupt line rises. Software clears the flag by reading it as 1 and then writing 0 to it. A write of 0 that was not preceded by such a read leaves the flag alone. The break address is 16 or 24 bits wide, chosen by the `ADDR_W` parameter. Software reaches everything through a byte-wide synchronous register port whose read data appears one cycle after the read strobe.

Top module: `addr_break_unit`

## Requirements
- R1: The status byte at offset 0 holds the match flag in bit 7 and the interrupt enable in bit 6, both 0 after reset. Bits 5..0 always read as 1 and ignore writes.
- R2: The break address occupies offsets 2 (bits 7:0), 3 (bits 15:8) and 4 (bits 23:16, 24-bit mode only). It resets to all ones and reads back what was written.
- R3: The control byte at offset 1 resets to 0. Its bits 1:0 pick the cycle type: 0 = opcode fetch (`bus_fetch`=1, `bus_write`=0), 1 = data read (`bus_fetch`=0, `bus_write`=0), 2 = write, 3 = any. Its bit 2 enables the data check, and with it clear a match depends on address and type alone.
- R4: A valid bus cycle that satisfies the selected condition sets the match flag at the next clock edge.
- R5: A status write with bit 7 = 0 clears the flag only if the most recent status access before it was a read that returned the flag as 1. Otherwise the flag stays set. Writing 1 to bit 7 never sets the flag.
- R6: When a hit and a clearing status write fall in the same cycle, the flag stays set.
- R7: The registered `irq` output is 1 exactly when the interrupt enable and the match flag are both 1. It changes at the same edge as they do.
- R8: With the data check on, a byte access (`bus_word`=0) compares bus bits 15:8 with break-data bits 15:8 at both even and odd addresses.
- R9: With the data check on, a word access at an even address compares all 16 bits. At an odd address it compares only bus bits 7:0 with break-data bits 7:0. The break data is written at offset 5 (bits 7:0) and offset 6 (bits 15:8).
- R10: An opcode-fetch break matches only a fetch whose address equals the break address exactly. A fetch of any following byte of the instruction does not match.
- R11: `reg_rdata` shows the addressed register one cycle after `reg_rd` and holds it until the next read. Unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | 16 | Bus data, both lanes |
| bus_write | input | 1 | 1 for a write cycle |
| bus_word | input | 1 | 1 for a word access, 0 for a byte access |
| bus_fetch | input | 1 | 1 for an opcode fetch |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a hit that lands in the same cycle as a clearing status write. That write only counts as a clear after a read that saw the flag set. The stimulus first makes a hit, reads the status to arm the clear, and then drives the matching bus cycle and the write of 0 together on one edge. The random phase reaches the odd-address word lane and the byte lane by steering about half of the addresses onto the break address. It also builds bus data from the break data with only one lane disturbed, so that a wrong lane choice changes the outcome.

// File: rtl/abu_pkg.sv
package abu_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_ANY   = 2'd3
  } cyc_sel_e;

  typedef struct packed {
    logic     data_en;
    cyc_sel_e sel;
  } ctl_t;

  localparam logic [2:0] OFF_STAT   = 3'd0;
  localparam logic [2:0] OFF_CTL    = 3'd1;
  localparam logic [2:0] OFF_BAR0   = 3'd2;
  localparam logic [2:0] OFF_BDR_LO = 3'd5;
  localparam logic [2:0] OFF_BDR_HI = 3'd6;
  localparam logic [5:0] STAT_FILL  = 6'h3F;
endpackage

// File: rtl/abu_compare.sv
module abu_compare
  import abu_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] bar,
  input  logic [15:0]       bdr,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_data,
  input  logic              bus_write,
  input  logic              bus_word,
  input  logic              bus_fetch,
  output logic              hit
);
  logic type_ok, addr_ok, hi_ok, lo_ok, data_ok;

  always_comb begin
    unique case (ctl.sel)
      CYC_FETCH: type_ok = bus_fetch && !bus_write;
      CYC_READ:  type_ok = !bus_fetch && !bus_write;
      CYC_WRITE: type_ok = bus_write;
      default:   type_ok = 1'b1;
    endcase
    addr_ok = (bus_addr == bar);
    hi_ok   = (bus_data[15:8] == bdr[15:8]);
    lo_ok   = (bus_data[7:0] == bdr[7:0]);
    if (!ctl.data_en)      data_ok = 1'b1;
    else if (!bus_word)    data_ok = hi_ok;
    else if (bus_addr[0])  data_ok = lo_ok;
    else                   data_ok = hi_ok && lo_ok;
    hit = bus_valid && type_ok && addr_ok && data_ok;
  end

  a_r8_byte_upper_lane: assert property (@(posedge clk) disable iff (rst)
    (hit && ctl.data_en && !bus_word) |-> (bus_data[15:8] == bdr[15:8]));
  a_r9_odd_word_lower_lane: assert property (@(posedge clk) disable iff (rst)
    (hit && ctl.data_en && bus_word && bus_addr[0]) |-> (bus_data[7:0] == bdr[7:0]));
  a_r10_exact_address: assert property (@(posedge clk) disable iff (rst)
    hit |-> (bus_addr == bar));
endmodule

// File: rtl/abu_regs.sv
module abu_regs
  import abu_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [2:0]        reg_off,
  input  logic [7:0]        reg_wdata,
  input  logic [7:0]        stat_byte,
  output logic [7:0]        reg_rdata,
  output ctl_t              ctl,
  output logic [ADDR_W-1:0] bar,
  output logic [15:0]       bdr
);
  localparam int NB = ADDR_W / 8;

  logic [7:0] rd_mux;
  logic [7:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst) ctl <= '0;
    else if (reg_wr && reg_off == OFF_CTL) ctl <= ctl_t'(reg_wdata[2:0]);
  end

  for (genvar i = 0; i < NB; i++) begin : g_bar
    always_ff @(posedge clk) begin
      if (rst) bar[i*8 +: 8] <= 8'hFF;
      else if (reg_wr && reg_off == 3'(OFF_BAR0 + i)) bar[i*8 +: 8] <= reg_wdata;
    end
  end

  // break data has no defined reset value
  always_ff @(posedge clk) begin
    if (reg_wr && reg_off == OFF_BDR_LO) bdr[7:0]  <= reg_wdata;
    if (reg_wr && reg_off == OFF_BDR_HI) bdr[15:8] <= reg_wdata;
  end

  always_comb begin
    rd_mux = 8'h00;
    case (reg_off)
      OFF_STAT:   rd_mux = stat_byte;
      OFF_CTL:    rd_mux = {5'b0, ctl};
      OFF_BDR_LO: rd_mux = bdr[7:0];
      OFF_BDR_HI: rd_mux = bdr[15:8];
      default: begin
        for (int j = 0; j < NB; j++)
          if (reg_off == 3'(OFF_BAR0 + j)) rd_mux = bar[j*8 +: 8];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 8'h00;
    else if (reg_rd) rd_q <= rd_mux;
  end
  assign reg_rdata = rd_q;

  a_r1_reserved_read_ones: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_off == OFF_STAT) |=> (reg_rdata[5:0] == STAT_FILL));
  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: rtl/abu_flag.sv
module abu_flag (
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic       stat_rd,
  input  logic       stat_wr,
  input  logic [1:0] wdata_hi,
  output logic       flag,
  output logic       ie,
  output logic       irq
);
  logic armed_q;
  logic flag_nxt, ie_nxt;
  logic clr_req;

  always_comb begin
    clr_req  = stat_wr && !wdata_hi[1] && armed_q;
    if (hit)          flag_nxt = 1'b1;
    else if (clr_req) flag_nxt = 1'b0;
    else              flag_nxt = flag;
    ie_nxt = stat_wr ? wdata_hi[0] : ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      ie      <= 1'b0;
      irq     <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag <= flag_nxt;
      ie   <= ie_nxt;
      irq  <= flag_nxt && ie_nxt;
      if (stat_wr)              armed_q <= 1'b0;
      else if (stat_rd && flag) armed_q <= 1'b1;
    end
  end

  a_r4_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  a_r5_unarmed_write_keeps: assert property (@(posedge clk) disable iff (rst)
    (flag && stat_wr && !armed_q) |=> flag);
  a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (hit && clr_req) |=> flag);
  a_r5_no_sw_set: assert property (@(posedge clk) disable iff (rst)
    (!flag && !hit) |=> !flag);
endmodule

// File: rtl/addr_break_unit.sv
module addr_break_unit
  import abu_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [2:0]        reg_off,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_data,
  input  logic              bus_write,
  input  logic              bus_word,
  input  logic              bus_fetch,
  output logic              irq
);
  ctl_t              ctl;
  logic [ADDR_W-1:0] bar;
  logic [15:0]       bdr;
  logic              hit, flag, ie;
  logic              stat_rd, stat_wr;

  assign stat_rd = reg_rd && reg_off == OFF_STAT;
  assign stat_wr = reg_wr && reg_off == OFF_STAT;

  abu_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .stat_byte({flag, ie, STAT_FILL}),
    .reg_rdata(reg_rdata), .ctl(ctl), .bar(bar), .bdr(bdr)
  );

  abu_compare #(.ADDR_W(ADDR_W)) u_cmp (
    .clk(clk), .rst(rst), .ctl(ctl), .bar(bar), .bdr(bdr),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_write(bus_write), .bus_word(bus_word), .bus_fetch(bus_fetch), .hit(hit)
  );

  abu_flag u_flag (
    .clk(clk), .rst(rst), .hit(hit), .stat_rd(stat_rd), .stat_wr(stat_wr),
    .wdata_hi(reg_wdata[7:6]), .flag(flag), .ie(ie), .irq(irq)
  );

  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && ie));
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (flag && ie) |-> irq);
endmodule

// File: tb/addr_break_unit_bench.sv
module addr_break_unit_bench;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_rd = 0, reg_wr = 0;
  logic [2:0] reg_off = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic bus_valid = 0, bus_write = 0, bus_word = 0, bus_fetch = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [15:0] bus_data = 0;
  logic irq;

  always #4 clk = ~clk;

  addr_break_unit #(.ADDR_W(AW)) u_addr_break_unit (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_write(bus_write),
    .bus_word(bus_word), .bus_fetch(bus_fetch), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic m_flag = 0, m_ie = 0, m_armed = 0;
  logic [2:0] m_ctl = 0;
  logic [AW-1:0] m_bar = '1;
  logic [15:0] m_bdr = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(logic [AW-1:0] a, logic [15:0] d,
                                   logic w, logic wd, logic f);
    logic t, dok;
    case (m_ctl[1:0])
      2'd0: t = f && !w;
      2'd1: t = !f && !w;
      2'd2: t = w;
      default: t = 1'b1;
    endcase
    if (!m_ctl[2]) dok = 1;
    else if (!wd)  dok = d[15:8] == m_bdr[15:8];
    else if (a[0]) dok = d[7:0] == m_bdr[7:0];
    else           dok = d == m_bdr;
    return t && dok && (a == m_bar);
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] off);
    case (off)
      3'd0: return {m_flag, m_ie, 6'h3F};
      3'd1: return {5'b0, m_ctl};
      3'd2: return m_bar[7:0];
      3'd3: return m_bar[15:8];
      3'd4: return m_bar[23:16];
      3'd5: return m_bdr[7:0];
      3'd6: return m_bdr[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic reg_write(logic [2:0] off, logic [7:0] v);
    @(negedge clk);
    reg_wr = 1; reg_off = off; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
    case (off)
      3'd0: begin
        if (m_armed && !v[7]) m_flag = 0;
        m_ie = v[6]; m_armed = 0;
      end
      3'd1: m_ctl = v[2:0];
      3'd2: m_bar[7:0] = v;
      3'd3: m_bar[15:8] = v;
      3'd4: m_bar[23:16] = v;
      3'd5: m_bdr[7:0] = v;
      3'd6: m_bdr[15:8] = v;
      default: ;
    endcase
  endtask

  task automatic reg_read(logic [2:0] off, string req);
    @(negedge clk);
    reg_rd = 1; reg_off = off;
    @(negedge clk);
    reg_rd = 0;
    chk(req, reg_rdata, exp_rd(off));
    if (off == 3'd0 && m_flag) m_armed = 1;
  endtask

  task automatic bus(logic [AW-1:0] a, logic [15:0] d, logic w, logic wd,
                     logic f, string req);
    @(negedge clk);
    bus_valid = 1; bus_addr = a; bus_data = d;
    bus_write = w; bus_word = wd; bus_fetch = f;
    @(negedge clk);
    bus_valid = 0;
    if (exp_hit(a, d, w, wd, f)) m_flag = 1;
    chk(req, irq, m_flag && m_ie);
  endtask

  task automatic clear_flag();
    reg_read(3'd0, "R5 read before clear");
    reg_write(3'd0, {1'b0, m_ie, 6'h00});
    chk("R5 cleared", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state
    chk("R7 irq after reset", irq, 0);
    reg_read(3'd0, "R1 status reset");
    reg_read(3'd1, "R3 control reset");
    for (int i = 2; i < 5; i++) reg_read(3'(i), "R2 bar reset ones");
    reg_read(3'd7, "R11 unused offset");
    // reserved bits ignore writes
    reg_write(3'd0, 8'h3F);
    reg_read(3'd0, "R1 reserved ignore");
    reg_write(3'd6, 8'hA5); reg_write(3'd5, 8'h3C);
    reg_write(3'd2, 8'h34); reg_write(3'd3, 8'h12); reg_write(3'd4, 8'h00);
    reg_read(3'd3, "R2 bar readback");
    reg_read(3'd6, "R11 bdr readback");
    // fetch break
    reg_write(3'd1, 8'h00);
    reg_write(3'd0, 8'h40);
    bus(24'h001235, 0, 0, 1, 1, "R10 second opcode byte");
    bus(24'h001234, 0, 0, 1, 0, "R3 data read not fetch");
    bus(24'h001234, 0, 1, 1, 0, "R3 write not fetch");
    bus(24'h001234, 0, 0, 1, 1, "R4 fetch first byte");
    chk("R4 irq high", irq, 1);
    // clear protocol
    reg_write(3'd0, 8'h40);
    chk("R5 unarmed write keeps", irq, 1);
    reg_read(3'd0, "R1 status flag set");
    reg_write(3'd0, 8'h40);
    chk("R5 armed write clears", irq, 0);
    reg_write(3'd0, 8'hC0);
    reg_read(3'd0, "R5 write one no set");
    // enable gating
    reg_write(3'd0, 8'h00);
    bus(24'h001234, 0, 0, 1, 1, "R7 disabled no irq");
    reg_write(3'd0, 8'h40);
    chk("R7 enable raises irq", irq, 1);
    clear_flag();
    // data lanes
    reg_write(3'd1, 8'h07);
    bus(24'h001234, 16'hA500, 0, 0, 0, "R8 byte upper lane hit");
    clear_flag();
    bus(24'h001234, 16'h00A5, 0, 0, 1, "R8 byte lower lane miss");
    bus(24'h001234, 16'hA53C, 1, 1, 0, "R9 even word hit");
    clear_flag();
    bus(24'h001234, 16'hA500, 1, 1, 0, "R9 even word partial miss");
    reg_write(3'd2, 8'h35);
    bus(24'h001235, 16'hFF3C, 0, 1, 0, "R9 odd word lower only");
    clear_flag();
    bus(24'h001235, 16'h3CA5, 0, 1, 0, "R9 odd word miss");
    // hit and clear in the same cycle
    bus(24'h001235, 16'h003C, 0, 1, 0, "R6 setup hit");
    reg_read(3'd0, "R6 arm");
    @(negedge clk);
    reg_wr = 1; reg_off = 3'd0; reg_wdata = 8'h40;
    bus_valid = 1; bus_addr = 24'h001235; bus_data = 16'h003C;
    bus_write = 0; bus_word = 1; bus_fetch = 0;
    @(negedge clk);
    reg_wr = 0; bus_valid = 0; m_armed = 0;
    chk("R6 set beats clear", irq, 1);
    reg_read(3'd0, "R6 flag still set");
    clear_flag();
    // random phase
    for (int it = 0; it < 600; it++) begin
      int unsigned r;
      r = $urandom_range(0, 9);
      if (r < 2) begin
        reg_write(3'd1, 8'($urandom_range(0, 7)));
        reg_write(3'(2 + $urandom_range(0, 2)), 8'($urandom));
        reg_write(3'(5 + $urandom_range(0, 1)), 8'($urandom));
        reg_read(3'($urandom_range(1, 6)), "R11 random readback");
      end else if (r < 8) begin
        logic [AW-1:0] a;
        logic [15:0] d;
        a = ($urandom_range(0, 1) != 0) ? m_bar : AW'($urandom);
        d = m_bdr;
        case ($urandom_range(0, 3))
          0: d[15:8] = 8'($urandom);
          1: d[7:0] = 8'($urandom);
          2: d = 16'($urandom);
          default: ;
        endcase
        bus(a, d, 1'($urandom), 1'($urandom), 1'($urandom), "R4 random cycle");
      end else begin
        if ($urandom_range(0, 1) != 0) reg_read(3'd0, "R1 random status");
        reg_write(3'd0, {1'($urandom), 1'($urandom), 6'($urandom)});
        chk("R5 random clear", irq, m_flag && m_ie);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule